// File: doc/BRIEF.md
# Sparse Recovery Iteration Sequencer

This block drives the outer loop of a greedy sparse-signal reconstruction. Each iteration makes one pass through three external kernels, each started with a one-cycle strobe and finished with a done strobe: a correlation of the residual against every dictionary column, a search for the column of largest correlation magnitude, and a least-squares solve that also produces the next residual. Between the search and the solve, the block adds the chosen column index to a support set that it keeps in its own registers.

A run begins with a start pulse. The block then asks the datapath to reload the residual from the measurement vector, empties the support set and clears the iteration counter. It loops until it has done as many iterations as the configured sparsity, up to 32, and then signals completion for one cycle. The least-squares kernel reads the support set through a random-access port and is told the size of its system, which grows by one on every iteration. If the search returns a column that is already in the support set, the run stops early with an error flag.

Top module: `sprs_iter_seq`

## Requirements
- R1: After reset, busy_o, done_o, dup_err_o and all kernel strobes are 0, and supp_count_o and iter_o are 0.
- R2: A start_i seen while idle is accepted. In the next cycle res_init_o is high for exactly one cycle, and supp_count_o, iter_o and dup_err_o read 0.
- R3: Each iteration strobes corr_start_o, then amax_start_o only after corr_done_i, then lsq_start_o only after amax_done_i and the append. Each strobe lasts one cycle, and at most one of res_init_o and the three kernel strobes is high in any cycle.
- R4: While lsq_start_o is high, lsq_size_o equals the iteration number t, counted from 1. This is also the number of support entries.
- R5: After the k-th lsq_done_i, done_o is high for exactly one cycle with iter_o equal to k. In the following cycle busy_o is 0.
- R6: Read address j on supp_rd_addr_i returns the index chosen in iteration j+1. supp_count_o gives the number of valid entries. Both hold after done until the next accepted start.
- R7: A sparsity above 32 runs as 32. A sparsity of 0 finishes with done_o and issues no kernel strobe.
- R8: If amax_idx_i at amax_done_i matches a valid support entry, the run ends at once: no append, no lsq_start_o, done_o pulses and dup_err_o rises. dup_err_o stays high until the next accepted start.
- R9: start_i is ignored while busy_o is high. The sequence, the latched sparsity and the support set are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request |
| sparsity_i | input | K_W | Requested iteration count, sampled at start |
| res_init_o | output | 1 | Pulse: load residual from the measurement vector |
| corr_start_o | output | 1 | Correlation kernel start |
| corr_done_i | input | 1 | Correlation kernel done |
| amax_start_o | output | 1 | Maximum-search kernel start |
| amax_done_i | input | 1 | Maximum-search kernel done |
| amax_idx_i | input | IDX_W | Column index found by the search, valid with amax_done_i |
| lsq_start_o | output | 1 | Least-squares/residual kernel start |
| lsq_done_i | input | 1 | Least-squares/residual kernel done |
| lsq_size_o | output | K_W | Current system size (support entries) |
| supp_rd_addr_i | input | AW | Support set read address |
| supp_rd_data_o | output | IDX_W | Support entry at the read address |
| supp_count_o | output | K_W | Number of valid support entries |
| iter_o | output | K_W | Completed iterations |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dup_err_o | output | 1 | Repeated index detected in the last run |

## Verification
The bench builds the block with its defaults: a capacity of 32 entries and 10-bit column indices. The full capacity can then be reached, and a request of 40 shows the clamp filling every slot. The 10-bit indices let the stub search return both 0 and the largest index, 1023. Stub kernels with fixed latencies feed a scoreboard of expected strobe events. The scenarios cover a repeated index both in the first possible slot and part way through a run, and a start that arrives mid-run.

// File: rtl/sprs_pkg.sv
// Shared types for the sparse recovery iteration sequencer.
// Assumes: nothing beyond the standard language.
package sprs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT,
        ST_CHECK,
        ST_CORR,
        ST_CWAIT,
        ST_AMAX,
        ST_AWAIT,
        ST_APPEND,
        ST_LSQ,
        ST_LWAIT,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/sprs_support_file.sv
// Support set storage: MAX_K column-index registers plus a valid count.
// Captures a candidate index, detects whether it is already held among the
// valid entries, appends it on request and serves a random-access read.
// Assumes: clr_i, cap_i and wr_i never coincide; the controller issues at
// most MAX_K appends between clears.
module sprs_support_file #(
    parameter int MAX_K = 32,
    parameter int IDX_W = 10,
    localparam int K_W  = $clog2(MAX_K + 1),
    localparam int AW   = (MAX_K > 1) ? $clog2(MAX_K) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cap_i,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] cand_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic             dup_hit_o,
    output logic [K_W-1:0]   count_o,
    output logic [IDX_W-1:0] rd_data_o
);

    logic [IDX_W-1:0] ent   [MAX_K];
    logic [MAX_K-1:0] hit;
    logic [K_W-1:0]   count_q;
    logic [IDX_W-1:0] cand_q;
    logic             room;

    assign room = (count_q < K_W'(MAX_K));

    // Latch the candidate index when the search kernel reports it.
    always_ff @(posedge clk) begin
        if (!rst_n)     cand_q <= '0;
        else if (cap_i) cand_q <= cand_i;
    end

    // Valid-entry count: cleared on a new run, bumped on each append.
    always_ff @(posedge clk) begin
        if (!rst_n)             count_q <= '0;
        else if (clr_i)         count_q <= '0;
        else if (wr_i && room)  count_q <= count_q + K_W'(1);
    end

    generate
        for (genvar i = 0; i < MAX_K; i++) begin : g_slot
            localparam logic [K_W-1:0] SLOT = K_W'(i);

            // One support slot, written when the count points at it.
            always_ff @(posedge clk) begin
                if (!rst_n)                         ent[i] <= '0;
                else if (wr_i && count_q == SLOT)   ent[i] <= cand_q;
            end

            // Match of the live candidate against a valid slot.
            assign hit[i] = (SLOT < count_q) && (ent[i] == cand_i);
        end
    endgenerate

    assign dup_hit_o = |hit;
    assign count_o   = count_q;
    assign rd_data_o = ent[rd_addr_i];

    // R3: the count moves only one step up or back to zero
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> (count_q == $past(count_q) + K_W'(1) || count_q == '0));

    // R7: never more entries than the capacity
    p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= K_W'(MAX_K));

    // R8: a repeated index is never appended
    p_no_dup_append_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && dup_hit_o) |=> !wr_i);

endmodule

// File: rtl/sprs_seq_fsm.sv
// Phase controller for the greedy recovery loop. Runs correlate, search,
// append and least-squares phases once per iteration until the latched
// sparsity is reached, or ends early when the search repeats an index.
// Assumes: each kernel answers every start with exactly one done strobe.
module sprs_seq_fsm
    import sprs_pkg::*;
#(
    parameter int MAX_K = 32,
    localparam int K_W  = $clog2(MAX_K + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [K_W-1:0] sparsity_i,
    input  logic           corr_done_i,
    input  logic           amax_done_i,
    input  logic           lsq_done_i,
    input  logic           dup_hit_i,
    output logic           clr_o,
    output logic           cap_o,
    output logic           wr_o,
    output logic           res_init_o,
    output logic           corr_start_o,
    output logic           amax_start_o,
    output logic           lsq_start_o,
    output logic [K_W-1:0] iter_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           dup_err_o
);

    seq_state_e     state, nxt;
    logic [K_W-1:0] k_q;
    logic [K_W-1:0] iter_q;
    logic           err_q;
    logic           accept;

    assign accept = (state == ST_IDLE) && start_i;

    // Next-state decode of the iteration loop.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_i) nxt = ST_INIT;
            ST_INIT:   nxt = ST_CHECK;
            ST_CHECK:  nxt = (iter_q < k_q) ? ST_CORR : ST_FIN;
            ST_CORR:   nxt = ST_CWAIT;
            ST_CWAIT:  if (corr_done_i) nxt = ST_AMAX;
            ST_AMAX:   nxt = ST_AWAIT;
            ST_AWAIT:  if (amax_done_i) nxt = dup_hit_i ? ST_FIN : ST_APPEND;
            ST_APPEND: nxt = ST_LSQ;
            ST_LSQ:    nxt = ST_LWAIT;
            ST_LWAIT:  if (lsq_done_i) nxt = ST_CHECK;
            ST_FIN:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Latched sparsity, clamped to the support capacity.
    always_ff @(posedge clk) begin
        if (!rst_n)      k_q <= '0;
        else if (accept) k_q <= (sparsity_i > K_W'(MAX_K)) ? K_W'(MAX_K) : sparsity_i;
    end

    // Iteration counter: cleared at start, advanced when least squares ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  iter_q <= '0;
        else if (accept)                             iter_q <= '0;
        else if (state == ST_LWAIT && lsq_done_i)    iter_q <= iter_q + K_W'(1);
    end

    // Sticky repeated-index flag, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          err_q <= 1'b0;
        else if (accept)                                     err_q <= 1'b0;
        else if (state == ST_AWAIT && amax_done_i && dup_hit_i) err_q <= 1'b1;
    end

    assign clr_o        = accept;
    assign cap_o        = (state == ST_AWAIT) && amax_done_i;
    assign wr_o         = (state == ST_APPEND);
    assign res_init_o   = (state == ST_INIT);
    assign corr_start_o = (state == ST_CORR);
    assign amax_start_o = (state == ST_AMAX);
    assign lsq_start_o  = (state == ST_LSQ);
    assign iter_o       = iter_q;
    assign busy_o       = (state != ST_IDLE);
    assign done_o       = (state == ST_FIN);
    assign dup_err_o    = err_q;

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a clean finish reports exactly the latched sparsity
    p_iter_eq_k_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dup_err_o) |-> (iter_q == k_q));

    // R3: the search starts only right after correlation reported done
    p_amax_after_corr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        amax_start_o |-> $past(corr_done_i));

    // R9: a start seen while busy never restarts the run
    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !res_init_o);

endmodule

// File: rtl/sprs_iter_seq.sv
// Top of the sparse recovery iteration sequencer: joins the phase controller
// to the support set storage and exposes kernel handshakes and the support
// read port.
// Assumes: kernels are external and handshake with single-cycle strobes.
module sprs_iter_seq #(
    parameter int MAX_K = 32,
    parameter int IDX_W = 10,
    localparam int K_W  = $clog2(MAX_K + 1),
    localparam int AW   = (MAX_K > 1) ? $clog2(MAX_K) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [K_W-1:0]   sparsity_i,
    output logic             res_init_o,
    output logic             corr_start_o,
    input  logic             corr_done_i,
    output logic             amax_start_o,
    input  logic             amax_done_i,
    input  logic [IDX_W-1:0] amax_idx_i,
    output logic             lsq_start_o,
    input  logic             lsq_done_i,
    output logic [K_W-1:0]   lsq_size_o,
    input  logic [AW-1:0]    supp_rd_addr_i,
    output logic [IDX_W-1:0] supp_rd_data_o,
    output logic [K_W-1:0]   supp_count_o,
    output logic [K_W-1:0]   iter_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             dup_err_o
);

    logic           clr, cap, wr, dup_hit;
    logic [K_W-1:0] count;

    sprs_seq_fsm #(.MAX_K(MAX_K)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sparsity_i   (sparsity_i),
        .corr_done_i  (corr_done_i),
        .amax_done_i  (amax_done_i),
        .lsq_done_i   (lsq_done_i),
        .dup_hit_i    (dup_hit),
        .clr_o        (clr),
        .cap_o        (cap),
        .wr_o         (wr),
        .res_init_o   (res_init_o),
        .corr_start_o (corr_start_o),
        .amax_start_o (amax_start_o),
        .lsq_start_o  (lsq_start_o),
        .iter_o       (iter_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .dup_err_o    (dup_err_o)
    );

    sprs_support_file #(.MAX_K(MAX_K), .IDX_W(IDX_W)) u_supp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .cap_i     (cap),
        .wr_i      (wr),
        .cand_i    (amax_idx_i),
        .rd_addr_i (supp_rd_addr_i),
        .dup_hit_o (dup_hit),
        .count_o   (count),
        .rd_data_o (supp_rd_data_o)
    );

    assign lsq_size_o   = count;
    assign supp_count_o = count;

    // R4: system size seen by least squares is the 1-based iteration number
    p_lsq_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lsq_start_o |-> (lsq_size_o == iter_o + K_W'(1)));

    // R3: at most one phase strobe per cycle
    p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_init_o, corr_start_o, amax_start_o, lsq_start_o}));

endmodule

// File: tb/test_sprs_iter_seq.sv
// Scoreboard bench: the driver pushes the expected phase events, the monitor
// pops and compares them as strobes appear; stub kernels answer with fixed latency.
module test_sprs_iter_seq;

    localparam int MAX_K = 32;
    localparam int IDX_W = 10;
    localparam int K_W   = $clog2(MAX_K + 1);
    localparam int AW    = $clog2(MAX_K);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [K_W-1:0]   sparsity_i = '0;
    logic             res_init_o, corr_start_o, amax_start_o, lsq_start_o;
    logic             corr_done_i = 1'b0, amax_done_i = 1'b0, lsq_done_i = 1'b0;
    logic [IDX_W-1:0] amax_idx_i = '0;
    logic [K_W-1:0]   lsq_size_o, supp_count_o, iter_o;
    logic [AW-1:0]    supp_rd_addr_i = '0;
    logic [IDX_W-1:0] supp_rd_data_o;
    logic             busy_o, done_o, dup_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    int pick_mem[64];
    int pick_ptr = 0;

    always #4 clk = ~clk;

    sprs_iter_seq #(.MAX_K(MAX_K), .IDX_W(IDX_W)) i_sprs_iter_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sparsity_i(sparsity_i),
        .res_init_o(res_init_o), .corr_start_o(corr_start_o), .corr_done_i(corr_done_i),
        .amax_start_o(amax_start_o), .amax_done_i(amax_done_i), .amax_idx_i(amax_idx_i),
        .lsq_start_o(lsq_start_o), .lsq_done_i(lsq_done_i), .lsq_size_o(lsq_size_o),
        .supp_rd_addr_i(supp_rd_addr_i), .supp_rd_data_o(supp_rd_data_o),
        .supp_count_o(supp_count_o), .iter_o(iter_o), .busy_o(busy_o),
        .done_o(done_o), .dup_err_o(dup_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ev(input int kind, input int data);
        return kind * 4096 + data;
    endfunction

    function automatic string tag_of(input int e);
        case (e / 4096)
            1: return "R2 init event";
            2: return "R3 corr event";
            3: return "R3 amax event";
            4: return "R4 lsq event";
            default: return "R5 done event";
        endcase
    endfunction

    task automatic observe(input int act);
        int exp;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected event", act, -1);
        end else begin
            exp = exp_q.pop_front();
            chk(act == exp, tag_of(exp), act, exp);
        end
    endtask

    // Monitor: turns strobes into events and compares with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_init_o)   observe(ev(1, 0));
            if (corr_start_o) observe(ev(2, 0));
            if (amax_start_o) observe(ev(3, 0));
            if (lsq_start_o)  observe(ev(4, int'(lsq_size_o)));
            if (done_o)       observe(ev(5, int'(dup_err_o) * 64 + int'(iter_o)));
        end
    end

    // Stub correlation kernel, latency 3.
    always begin
        @(negedge clk);
        if (corr_start_o) begin
            repeat (3) @(negedge clk);
            corr_done_i = 1'b1;
            @(negedge clk);
            corr_done_i = 1'b0;
        end
    end

    // Stub maximum search, latency 2, index from the pick list.
    always begin
        @(negedge clk);
        if (amax_start_o) begin
            repeat (2) @(negedge clk);
            amax_idx_i  = IDX_W'(pick_mem[pick_ptr]);
            pick_ptr++;
            amax_done_i = 1'b1;
            @(negedge clk);
            amax_done_i = 1'b0;
        end
    end

    // Stub least-squares kernel, latency 4.
    always begin
        @(negedge clk);
        if (lsq_start_o) begin
            repeat (4) @(negedge clk);
            lsq_done_i = 1'b1;
            @(negedge clk);
            lsq_done_i = 1'b0;
        end
    end

    // Driver: predicts the event stream, runs one job, checks results.
    task automatic run_job(input int k, input bit poke_busy);
        int  keff;
        int  n_ok;
        bit  dup;
        keff = (k > MAX_K) ? MAX_K : k;
        n_ok = keff;
        dup  = 1'b0;
        exp_q.push_back(ev(1, 0));
        for (int t = 0; t < keff; t++) begin
            exp_q.push_back(ev(2, 0));
            exp_q.push_back(ev(3, 0));
            for (int j = 0; j < t; j++)
                if (pick_mem[j] == pick_mem[t]) dup = 1'b1;
            if (dup) begin
                n_ok = t;
                break;
            end
            exp_q.push_back(ev(4, t + 1));
        end
        exp_q.push_back(ev(5, (dup ? 64 : 0) + n_ok));

        pick_ptr   = 0;
        sparsity_i = K_W'(k);
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        chk(res_init_o == 1'b1, "R2 res_init after start", int'(res_init_o), 1);
        chk(supp_count_o == '0, "R2 support cleared", int'(supp_count_o), 0);
        chk(iter_o == '0, "R2 iteration cleared", int'(iter_o), 0);
        chk(dup_err_o == 1'b0, "R8 error cleared by start", int'(dup_err_o), 0);
        @(negedge clk);
        chk(res_init_o == 1'b0, "R2 res_init one cycle", int'(res_init_o), 0);

        if (poke_busy) begin
            repeat (4) @(negedge clk);
            sparsity_i = K_W'(1);
            start_i    = 1'b1;
            @(negedge clk);
            start_i    = 1'b0;
        end

        while (!done_o) @(negedge clk);
        chk(int'(iter_o) == n_ok, "R5 iteration count at done", int'(iter_o), n_ok);
        chk(dup_err_o == dup, "R8 error flag at done", int'(dup_err_o), int'(dup));
        @(negedge clk);
        chk(done_o == 1'b0, "R5 done single cycle", int'(done_o), 0);
        chk(busy_o == 1'b0, "R5 idle after done", int'(busy_o), 0);
        chk(dup_err_o == dup, "R8 error flag held", int'(dup_err_o), int'(dup));

        chk(int'(supp_count_o) == n_ok, "R6 support count", int'(supp_count_o), n_ok);
        for (int j = 0; j < n_ok; j++) begin
            supp_rd_addr_i = AW'(j);
            #1;
            chk(int'(supp_rd_data_o) == pick_mem[j], "R6 support entry",
                int'(supp_rd_data_o), pick_mem[j]);
        end
        chk(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", int'(busy_o), 0);
        chk(supp_count_o == '0 && iter_o == '0, "R1 counters zero", int'(supp_count_o), 0);
        chk(dup_err_o == 1'b0, "R1 error low", int'(dup_err_o), 0);
        chk({res_init_o, corr_start_o, amax_start_o, lsq_start_o} == 4'b0,
            "R1 strobes low", int'(corr_start_o), 0);

        // R3 R4 R6: basic run including index extremes
        pick_mem[0] = 7; pick_mem[1] = 0; pick_mem[2] = 100; pick_mem[3] = 1023;
        run_job(4, 1'b0);

        // R9: start during the run is ignored
        for (int j = 0; j < 6; j++) pick_mem[j] = 40 + 3 * j;
        run_job(6, 1'b1);

        // R7: zero sparsity
        run_job(0, 1'b0);

        // R7: request above capacity is clamped to 32
        for (int j = 0; j < 40; j++) pick_mem[j] = (j * 31 + 5) % 1024;
        run_job(40, 1'b0);

        // R8: repeated index in the middle of a run
        pick_mem[0] = 5; pick_mem[1] = 9; pick_mem[2] = 5; pick_mem[3] = 1; pick_mem[4] = 2;
        run_job(5, 1'b0);

        // R8: next start clears the flag, clean run follows
        pick_mem[0] = 11; pick_mem[1] = 12;
        run_job(2, 1'b0);

        // R8: repeat on the earliest possible iteration
        pick_mem[0] = 8; pick_mem[1] = 8; pick_mem[2] = 3;
        run_job(3, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R5 watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule